// File: doc/BRIEF.md
# Bounded Software Stack Pointer Unit

This unit owns the software stack pointer of a 16-bit processor whose data space is byte addressed. The stack grows toward higher addresses. The pointer always holds the address of the next free word. A single-word push stores its operand at the pointer and then advances the pointer by two. A pop first steps the pointer back by two and then reads the word there. Subroutine calls and exceptions save a 23-bit program counter as a two-word frame over two consecutive cycles.

Each stack access is checked against two bounds before it reaches memory. The first is a programmable ceiling register. The second is a fixed floor that keeps the stack out of the low special-register region. An access that breaks either bound reaches no memory, leaves the pointer unchanged and raises a one-cycle error trap.

The pointer and the ceiling are loaded through a small register write port. The ceiling has no defined reset value. Ceiling checks therefore stay off until software has written it at least once.

Top module: `spu_stack_unit`

## Requirements
- R1: While reset is held, the pointer is set to 0x0800, and `trap`, `busy`, `pop_valid`, `mem_we` and `mem_re` are low.
- R2: An accepted single push (op code 0) drives `mem_we` in the same cycle, with `mem_addr` equal to the pointer and `mem_wdata` equal to `push_data`. From the next cycle the pointer reads two higher.
- R3: An accepted pop (op code 1) drives `mem_re` in the same cycle, at the pointer minus two. From the next cycle the pointer reads two lower, and `pop_valid` is high for one cycle with `pop_data` equal to the word stored at that address.
- R4: Bit 0 of the pointer and of the ceiling always reads 0, whatever value is written through the register port (`reg_sel` 0 selects the pointer, 1 selects the ceiling).
- R5: A single push made while the pointer equals the ceiling completes normally. A push made while the pointer is above the ceiling causes no memory write, keeps the pointer, and sets `trap` high for exactly the next cycle.
- R6: A push with the pointer below 0x0800, or a pop whose target address (pointer minus two) is below 0x0800, causes no memory access, keeps the pointer, and sets `trap` for the next cycle.
- R7: A call (op code 2) writes PC bits 15:0 at the pointer in the request cycle. In the following cycle, while `busy` is high, it writes PC bits 22:16 zero-extended to 16 bits at pointer plus two. The pointer ends four higher. Requests presented while `busy` is high are ignored.
- R8: An exception (op code 3) builds the same frame as a call, except that its second word is the status byte in bits 15:8, a 0 in bit 7, and PC bits 22:16 in bits 6:0.
- R9: A two-word push traps, with neither word written, when its second word would land above the ceiling, that is when the pointer plus two exceeds the ceiling.
- R10: Until the ceiling has been written once after reset, no push raises an overflow trap.
- R11: A ceiling write presented in the same cycle as a stack request is already used in that request's bound check.
- R12: A pointer write through the register port is ignored in any cycle where a stack request is accepted or `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Stack request present |
| req_op | input | 2 | 0 push, 1 pop, 2 call frame, 3 exception frame |
| push_data | input | 16 | Word for a single push |
| pc_in | input | 23 | Program counter saved by a frame push |
| stat_in | input | 8 | Status byte saved by an exception frame |
| busy | output | 1 | Second frame word in progress; requests ignored |
| pop_valid | output | 1 | `pop_data` holds a popped word |
| pop_data | output | 16 | Popped word |
| trap | output | 1 | One-cycle stack-error pulse |
| mem_we | output | 1 | Data-memory write strobe |
| mem_re | output | 1 | Data-memory read strobe |
| mem_addr | output | 16 | Data-memory byte address |
| mem_wdata | output | 16 | Data-memory write word |
| mem_rdata | input | 16 | Data-memory read word, one cycle after `mem_re` |
| reg_we | input | 1 | Register port write strobe |
| reg_sel | input | 1 | 0 pointer, 1 ceiling |
| reg_wdata | input | 16 | Register port write value |
| sp_out | output | 16 | Current pointer |
| lim_out | output | 16 | Current ceiling |

## Verification
Memory strobes, address and write data are combinational on an accepted request, so they are due in the request cycle itself. The pointer, the trap pulse, `pop_valid` and `busy` change at the first clock edge after the request. The second frame word follows in the cycle after the first, and the pointer settles at its final value one edge after that. The bench changes inputs just after a rising edge. A monitor compares every memory write and every popped word against a scoreboard at the falling edge of the cycle where each is due, and the direct checks on the pointer, the trap and `busy` are made one edge after each request.

// File: rtl/spu_pkg.sv
// Shared types for the stack pointer unit.
// Assumes a 2-bit operation code on the request port.
package spu_pkg;
    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_POP  = 2'd1,
        OP_CALL = 2'd2,
        OP_EXC  = 2'd3
    } stk_op_e;

    localparam logic SEL_PTR = 1'b0;
    localparam logic SEL_LIM = 1'b1;

    // True for the operations that build a two-word frame
    function automatic logic is_frame(stk_op_e op);
        return (op == OP_CALL) || (op == OP_EXC);
    endfunction
endpackage

// File: rtl/spu_ptr_regs.sv
// Pointer and ceiling registers.
// The pointer is written by the sequencer, or by the register port when it
// is not blocked. The ceiling has no reset; a valid flag marks its first write.
// A ceiling write is forwarded to the comparator in the same cycle.
module spu_ptr_regs #(
    parameter int          AW      = 16,
    parameter int unsigned SP_INIT = 'h0800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic          reg_sel,
    input  logic [AW-1:0] reg_wdata,
    input  logic          wr_block,
    input  logic          upd_en,
    input  logic [AW-1:0] upd_val,
    output logic [AW-1:0] sp_q,
    output logic [AW-1:0] lim_q,
    output logic [AW-1:0] lim_eff,
    output logic          lim_ok
);
    import spu_pkg::*;

    localparam logic [AW-1:0] ALIGN = ~AW'(1);

    logic          lim_seen_q;
    logic          lim_wr;
    logic          ptr_wr;
    logic [AW-1:0] wdata_al;

    assign wdata_al = reg_wdata & ALIGN;
    assign lim_wr   = reg_we && (reg_sel == SEL_LIM);
    assign ptr_wr   = reg_we && (reg_sel == SEL_PTR) && !wr_block;

    // Forward a same-cycle ceiling write to the comparator
    always_comb begin
        lim_eff = lim_wr ? wdata_al : lim_q;
        lim_ok  = lim_seen_q || lim_wr;
    end

    // Pointer register: the stack update wins over the register port
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= AW'(SP_INIT) & ALIGN;
        else if (upd_en)
            sp_q <= upd_val & ALIGN;
        else if (ptr_wr)
            sp_q <= wdata_al;
    end

    // Ceiling register: intentionally left without reset
    always_ff @(posedge clk) begin
        if (lim_wr)
            lim_q <= wdata_al;
    end

    // Ceiling-valid flag: cleared by reset, set by the first ceiling write
    always_ff @(posedge clk) begin
        if (!rst_n)
            lim_seen_q <= 1'b0;
        else if (lim_wr)
            lim_seen_q <= 1'b1;
    end
endmodule

// File: rtl/spu_bound_chk.sv
// Bound comparator for one stack request.
// Overflow: the highest word a push writes lies above the ceiling (pushes
// only, and only once the ceiling is valid). Underflow: the address
// generated lies below the fixed floor. Comparisons use one extra bit so
// that pointer plus two cannot wrap.
module spu_bound_chk #(
    parameter int          AW    = 16,
    parameter int unsigned FLOOR = 'h0800
) (
    input  spu_pkg::stk_op_e op,
    input  logic [AW-1:0]    sp,
    input  logic [AW-1:0]    lim,
    input  logic             lim_ok,
    output logic             ovf,
    output logic             unf
);
    import spu_pkg::*;

    localparam logic [AW:0] FLOOR_X = (AW+1)'(FLOOR);
    localparam logic [AW:0] TWO_X   = (AW+1)'(2);

    logic [AW:0] sp_x;
    logic [AW:0] top_x;
    logic        is_push;

    // Highest address written by the request and the two bound tests
    always_comb begin
        sp_x    = {1'b0, sp};
        is_push = (op != OP_POP);
        top_x   = is_frame(op) ? sp_x + TWO_X : sp_x;
        ovf     = is_push && lim_ok && (top_x > {1'b0, lim});
        unf     = is_push ? (sp_x < FLOOR_X) : (sp_x < FLOOR_X + TWO_X);
    end
endmodule

// File: rtl/spu_frame_seq.sv
// Access sequencer. It accepts one request per cycle while not busy, drives
// the memory port, and runs the second word of a call or exception frame in
// the following cycle. A request that breaks a bound makes no access and
// causes a one-cycle trap pulse. Memory reads return one cycle after the
// read strobe.
module spu_frame_seq #(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int PCW = 23,
    parameter int SRW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  spu_pkg::stk_op_e op,
    input  logic [DW-1:0]    push_data,
    input  logic [PCW-1:0]   pc_in,
    input  logic [SRW-1:0]   stat_in,
    input  logic             ovf,
    input  logic             unf,
    input  logic [AW-1:0]    sp,
    input  logic [DW-1:0]    mem_rdata,
    output logic             accept,
    output logic             busy,
    output logic             upd_en,
    output logic [AW-1:0]    upd_val,
    output logic             mem_we,
    output logic             mem_re,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             trap,
    output logic             pop_valid,
    output logic [DW-1:0]    pop_data
);
    import spu_pkg::*;

    localparam int          PC_HI_W = PCW - DW;
    localparam logic [AW-1:0] STEP  = AW'(2);

    logic          second_q;
    logic [DW-1:0] hi_q;
    logic          rd_pend_q;
    logic          trap_q;
    logic          err;
    logic          go;
    logic [DW-1:0] hi_next;

    assign accept = req_valid && !second_q;
    assign err    = ovf || unf;
    assign go     = accept && !err;

    // Second frame word: zero-extended for calls, status byte on top for exceptions
    always_comb begin
        if (op == OP_EXC)
            hi_next = DW'({stat_in, 1'b0, pc_in[PCW-1:DW]});
        else
            hi_next = DW'(pc_in[PCW-1:DW]);
    end

    // Memory port and pointer update for the current cycle
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = sp;
        mem_wdata = push_data;
        upd_en    = 1'b0;
        upd_val   = sp;
        if (second_q) begin
            mem_we    = 1'b1;
            mem_wdata = hi_q;
            upd_en    = 1'b1;
            upd_val   = sp + STEP;
        end else if (go) begin
            unique case (op)
                OP_PUSH: begin
                    mem_we  = 1'b1;
                    upd_en  = 1'b1;
                    upd_val = sp + STEP;
                end
                OP_POP: begin
                    mem_re   = 1'b1;
                    mem_addr = sp - STEP;
                    upd_en   = 1'b1;
                    upd_val  = sp - STEP;
                end
                default: begin
                    mem_we    = 1'b1;
                    mem_wdata = pc_in[DW-1:0];
                    upd_en    = 1'b1;
                    upd_val   = sp + STEP;
                end
            endcase
        end
    end

    // Sequencer state: frame phase, latched high word, read pending, trap pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_q  <= 1'b0;
            hi_q      <= '0;
            rd_pend_q <= 1'b0;
            trap_q    <= 1'b0;
        end else begin
            trap_q    <= accept && err;
            rd_pend_q <= go && (op == OP_POP);
            second_q  <= go && is_frame(op);
            if (go && is_frame(op))
                hi_q <= hi_next;
        end
    end

    assign busy      = second_q;
    assign trap      = trap_q;
    assign pop_valid = rd_pend_q;
    assign pop_data  = mem_rdata;

    // The packed exception word must fill exactly one data word
    initial begin
        if (SRW + 1 + PC_HI_W != DW)
            $display("spu_frame_seq: frame word packing width mismatch");
    end
endmodule

// File: rtl/spu_stack_unit.sv
// Top of the bounded stack pointer unit. It ties the register block, the
// bound comparator and the access sequencer together. It assumes a
// word-wide data memory with byte addresses and a one-cycle read latency.
module spu_stack_unit #(
    parameter int          AW      = 16,
    parameter int          DW      = 16,
    parameter int          PCW     = 23,
    parameter int          SRW     = 8,
    parameter int unsigned SP_INIT = 'h0800,
    parameter int unsigned FLOOR   = 'h0800
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [1:0]     req_op,
    input  logic [DW-1:0]  push_data,
    input  logic [PCW-1:0] pc_in,
    input  logic [SRW-1:0] stat_in,
    output logic           busy,
    output logic           pop_valid,
    output logic [DW-1:0]  pop_data,
    output logic           trap,
    output logic           mem_we,
    output logic           mem_re,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           reg_we,
    input  logic           reg_sel,
    input  logic [AW-1:0]  reg_wdata,
    output logic [AW-1:0]  sp_out,
    output logic [AW-1:0]  lim_out
);
    import spu_pkg::*;

    stk_op_e       op;
    logic [AW-1:0] sp_q;
    logic [AW-1:0] lim_q;
    logic [AW-1:0] lim_eff;
    logic          lim_ok;
    logic          ovf;
    logic          unf;
    logic          accept;
    logic          upd_en;
    logic [AW-1:0] upd_val;

    assign op = stk_op_e'(req_op);

    spu_ptr_regs #(.AW(AW), .SP_INIT(SP_INIT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .wr_block  (accept || busy),
        .upd_en    (upd_en),
        .upd_val   (upd_val),
        .sp_q      (sp_q),
        .lim_q     (lim_q),
        .lim_eff   (lim_eff),
        .lim_ok    (lim_ok)
    );

    spu_bound_chk #(.AW(AW), .FLOOR(FLOOR)) u_chk_bounds (
        .op     (op),
        .sp     (sp_q),
        .lim    (lim_eff),
        .lim_ok (lim_ok),
        .ovf    (ovf),
        .unf    (unf)
    );

    spu_frame_seq #(.AW(AW), .DW(DW), .PCW(PCW), .SRW(SRW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .op        (op),
        .push_data (push_data),
        .pc_in     (pc_in),
        .stat_in   (stat_in),
        .ovf       (ovf),
        .unf       (unf),
        .sp        (sp_q),
        .mem_rdata (mem_rdata),
        .accept    (accept),
        .busy      (busy),
        .upd_en    (upd_en),
        .upd_val   (upd_val),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .trap      (trap),
        .pop_valid (pop_valid),
        .pop_data  (pop_data)
    );

    assign sp_out  = sp_q;
    assign lim_out = lim_q;
endmodule

// File: rtl/spu_stack_unit_chk.sv
// Property checker for the stack pointer unit, bound to the top module.
module spu_stack_unit_chk #(
    parameter int          AW      = 16,
    parameter int          DW      = 16,
    parameter int          PCW     = 23,
    parameter int unsigned SP_INIT = 'h0800
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    req_op,
    input logic          busy,
    input logic          pop_valid,
    input logic          trap,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [AW-1:0] sp_out
);
    import spu_pkg::*;

    localparam int PC_HI_W = PCW - DW;

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (sp_out == AW'(SP_INIT)) && !busy && !trap && !pop_valid);

    // R2: writes go to the current pointer, which then advances by two
    a_r2_write_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == sp_out);
    a_r2_sp_advance: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_out == $past(sp_out) + AW'(2));

    // R3: reads go below the pointer, data follows one cycle later
    a_r3_read_below_sp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> mem_addr == sp_out - AW'(2));
    a_r3_pop_result: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> pop_valid && (sp_out == $past(sp_out) - AW'(2)));

    // R4: pointer stays word aligned
    a_r4_sp_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        sp_out[0] == 1'b0);

    // R5: a trap leaves the pointer where it was
    a_r5_trap_holds_sp: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> sp_out == $past(sp_out));

    // R6: a trapped request made no memory access
    a_r6_trap_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $past(!mem_we && !mem_re));

    // R7: the busy cycle writes the second word and lasts one cycle
    a_r7_busy_writes: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mem_we);
    a_r7_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    a_r7_call_hi_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ($past(req_op) == OP_CALL)) |-> mem_wdata[DW-1:PC_HI_W] == '0);
endmodule

bind spu_stack_unit spu_stack_unit_chk #(
    .AW(AW), .DW(DW), .PCW(PCW), .SP_INIT(SP_INIT)
) u_prop_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_op    (req_op),
    .busy      (busy),
    .pop_valid (pop_valid),
    .trap      (trap),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sp_out    (sp_out)
);

// File: tb/spu_stack_unit_bench.sv
// Scoreboard bench: tasks queue expected writes and pops, a monitor checks them.
module spu_stack_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_op;
    logic [15:0] push_data;
    logic [22:0] pc_in;
    logic [7:0]  stat_in;
    logic        busy, pop_valid, trap, mem_we, mem_re;
    logic [15:0] pop_data, mem_addr, mem_wdata, mem_rdata;
    logic        reg_we, reg_sel;
    logic [15:0] reg_wdata, sp_out, lim_out;

    always #5 clk = ~clk;

    spu_stack_unit u_spu_stack_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .push_data(push_data), .pc_in(pc_in), .stat_in(stat_in), .busy(busy),
        .pop_valid(pop_valid), .pop_data(pop_data), .trap(trap),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .sp_out(sp_out),
        .lim_out(lim_out)
    );

    // Word memory with one-cycle read latency
    logic [15:0] ram [4096];
    logic [15:0] rdata_q;
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[12:1]] <= mem_wdata;
        if (mem_re) rdata_q <= ram[mem_addr[12:1]];
    end
    assign mem_rdata = rdata_q;

    typedef struct { logic [15:0] a; logic [15:0] d; string tag; } wr_t;
    typedef struct { logic [15:0] d; string tag; } rd_t;
    wr_t exp_wr[$];
    rd_t exp_rd[$];
    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    function automatic void check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endfunction

    function automatic void exp_w(logic [15:0] a, logic [15:0] d, string tag);
        exp_wr.push_back('{a, d, tag});
    endfunction

    function automatic void exp_r(logic [15:0] d, string tag);
        exp_rd.push_back('{d, tag});
    endfunction

    // Monitor: compares memory writes and popped words with the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_we) begin
                if (exp_wr.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R5_R6 unexpected write: actual %h@%h expected none",
                             mem_wdata, mem_addr);
                end else begin
                    wr_t w;
                    w = exp_wr.pop_front();
                    check(w.tag, "write addr", 32'(mem_addr), 32'(w.a));
                    check(w.tag, "write data", 32'(mem_wdata), 32'(w.d));
                end
            end
            if (pop_valid) begin
                if (exp_rd.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R6 unexpected pop: actual %h expected none", pop_data);
                end else begin
                    rd_t r;
                    r = exp_rd.pop_front();
                    check(r.tag, "pop data", 32'(pop_data), 32'(r.d));
                end
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic [15:0] d,
                         input logic [22:0] pc, input logic [7:0] st);
        req_valid = 1'b1; req_op = op; push_data = d; pc_in = pc; stat_in = st;
        @(posedge clk); #1;
        req_valid = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_write(input logic sel, input logic [15:0] v);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; push_data = '0;
        pc_in = '0; stat_in = '0; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        repeat (3) @(posedge clk); #1;
        // R1: reset state
        check("R1", "sp", 32'(sp_out), 32'h0800);
        check("R1", "trap", 32'(trap), 32'd0);
        check("R1", "busy", 32'(busy), 32'd0);
        check("R1", "mem_we", 32'(mem_we), 32'd0);
        rst_n = 1'b1;

        // R2: two pushes
        exp_w(16'h0800, 16'hA5A5, "R2"); issue(2'd0, 16'hA5A5, '0, '0);
        check("R2", "sp", 32'(sp_out), 32'h0802);
        exp_w(16'h0802, 16'h1234, "R2"); issue(2'd0, 16'h1234, '0, '0);
        check("R2", "sp", 32'(sp_out), 32'h0804);

        // R3: pops return words in reverse order
        exp_r(16'h1234, "R3"); issue(2'd1, '0, '0, '0);
        check("R3", "sp", 32'(sp_out), 32'h0802);
        exp_r(16'hA5A5, "R3"); issue(2'd1, '0, '0, '0);
        check("R3", "sp", 32'(sp_out), 32'h0800);

        // R6: pop below the floor
        issue(2'd1, '0, '0, '0);
        check("R6", "trap", 32'(trap), 32'd1);
        check("R6", "sp", 32'(sp_out), 32'h0800);
        @(posedge clk); #1;
        check("R6", "trap pulse end", 32'(trap), 32'd0);

        // R4: pointer write is aligned; R6: push below the floor
        reg_write(1'b0, 16'h0601);
        check("R4", "sp aligned", 32'(sp_out), 32'h0600);
        issue(2'd0, 16'hBEEF, '0, '0);
        check("R6", "trap", 32'(trap), 32'd1);
        check("R6", "sp", 32'(sp_out), 32'h0600);
        reg_write(1'b0, 16'h1001);

        // R10: no overflow check before the ceiling is written
        exp_w(16'h1000, 16'h1111, "R10"); issue(2'd0, 16'h1111, '0, '0);
        check("R10", "trap", 32'(trap), 32'd0);
        check("R10", "sp", 32'(sp_out), 32'h1002);

        // R4: ceiling aligned
        reg_write(1'b1, 16'h1003);
        check("R4", "lim aligned", 32'(lim_out), 32'h1002);

        // R5: push at the ceiling passes, above it traps
        exp_w(16'h1002, 16'h2222, "R5"); issue(2'd0, 16'h2222, '0, '0);
        check("R5", "trap at limit", 32'(trap), 32'd0);
        check("R5", "sp", 32'(sp_out), 32'h1004);
        issue(2'd0, 16'h3333, '0, '0);
        check("R5", "trap above limit", 32'(trap), 32'd1);
        check("R5", "sp held", 32'(sp_out), 32'h1004);

        // R11: same-cycle ceiling write is used by the check
        reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h1010;
        exp_w(16'h1004, 16'h4444, "R11"); issue(2'd0, 16'h4444, '0, '0);
        check("R11", "raised limit", 32'(trap), 32'd0);
        check("R11", "sp", 32'(sp_out), 32'h1006);
        reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h1000;
        issue(2'd0, 16'h5555, '0, '0);
        check("R11", "lowered limit", 32'(trap), 32'd1);

        // R9: frame whose second word exceeds the ceiling
        reg_write(1'b1, 16'h1006);
        issue(2'd2, '0, 23'h5ABCDE, '0);
        check("R9", "trap", 32'(trap), 32'd1);
        check("R9", "sp", 32'(sp_out), 32'h1006);

        // R7: call frame, R12: pointer write during busy ignored
        reg_write(1'b1, 16'h1008);
        exp_w(16'h1006, 16'hBCDE, "R7"); exp_w(16'h1008, 16'h005A, "R7");
        issue(2'd2, '0, 23'h5ABCDE, '0);
        check("R7", "busy", 32'(busy), 32'd1);
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 16'h0900;
        issue(2'd0, 16'hDEAD, '0, '0);
        check("R7", "busy end", 32'(busy), 32'd0);
        check("R12", "sp after busy write", 32'(sp_out), 32'h100A);

        // R8: exception frame
        reg_write(1'b1, 16'h1FFE);
        exp_w(16'h100A, 16'h1234, "R8"); exp_w(16'h100C, 16'hC37F, "R8");
        issue(2'd3, '0, 23'h7F1234, 8'hC3);
        check("R8", "busy", 32'(busy), 32'd1);
        @(posedge clk); #1;
        check("R8", "sp", 32'(sp_out), 32'h100E);

        // R12: pointer write in an accept cycle ignored
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 16'h0A00;
        exp_w(16'h100E, 16'h7777, "R12"); issue(2'd0, 16'h7777, '0, '0);
        check("R12", "sp", 32'(sp_out), 32'h1010);

        // R3: unwind the frame
        exp_r(16'h7777, "R3"); issue(2'd1, '0, '0, '0);
        check("R3", "sp", 32'(sp_out), 32'h100E);
        exp_r(16'hC37F, "R3"); issue(2'd1, '0, '0, '0);
        exp_r(16'h1234, "R3"); issue(2'd1, '0, '0, '0);
        check("R3", "sp", 32'(sp_out), 32'h100A);
        @(posedge clk); #1;
        check("R2", "writes left", 32'(exp_wr.size()), 32'd0);
        check("R3", "pops left", 32'(exp_rd.size()), 32'd0);
        finish_run();
    end
endmodule